// File: doc/BRIEF.md
# Flash Byte Program-and-Verify Sequencer

This block sits on the host side of a parallel NOR flash device. It writes one byte into the device through the device's command interface and then confirms that the byte was stored. A single-cycle request carries the target address and data byte. The sequencer then runs a program-setup write, the program write, a timed wait for the program operation, a verify-command write, a timed settling wait and a read-back. It compares the byte it reads with the intended byte. On a mismatch it repeats the program/verify pair, up to a fixed number of attempts.

When the sequence ends, whether it passed or gave up, the sequencer writes the read command so that the device is back in plain read mode. Only then does it pulse `done` or `fail` for one cycle. All waits and strobe widths are given in nanoseconds as parameters. The block converts each one to clock cycles, rounding up. The flash-side pins are a chip enable, a write strobe, an output enable, an address bus, and a data port split into output, output-enable and input.

Top module: `fpv_seq`

## Requirements
- R1: While reset is held and after it is released, the chip enable, write strobe and output enable are high, the data port is not driven, and busy, done and fail are low.
- R2: A request in idle captures address and data. The first bus write carries the setup command 40h, and the next write carries the target address (taken on the strobe's falling edge) and the target data (taken on its rising edge).
- R3: Every write strobe stays low for at least 80 ns and high for at least 20 ns between strobes. Write data is stable at least 50 ns before the rising strobe edge, and the address does not change within 60 ns after the falling edge while the chip is enabled.
- R4: At least 10 us pass from the rising strobe edge that ends a program write to the falling edge of the next strobe.
- R5: After each program write, the verify command C0h is written, and the output enable falls no sooner than 6 us after that write's rising strobe edge.
- R6: The data port is never driven while the output enable is low.
- R7: When the read-back equals the target byte, the command 00h is written, then done is high for exactly one cycle with busy low in that cycle.
- R8: On a mismatch the program/verify pair repeats. A byte that verifies on attempt k (k up to 25, including the 25th) ends with done after exactly k program writes.
- R9: After 25 failed verifies, the command 00h is written, then fail is high for one cycle. No 26th program write occurs.
- R10: A request raised while busy is ignored: the target of the running sequence is kept, and the ignored address is never programmed.
- R11: done and fail are never high together, and each accepted request ends in exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle program request, taken only when idle |
| req_addr | input | ADDR_W | Byte address to program |
| req_data | input | DATA_W | Byte value to program |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: byte programmed and verified |
| fail | output | 1 | One-cycle pulse: attempts exhausted |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dout | output | DATA_W | Flash data written by the host |
| fl_doe | output | 1 | Host drives the flash data bus when high |
| fl_din | input | DATA_W | Flash data read back |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The hardest conditions to reach from the ports are the retry boundary: a byte that verifies only on the 25th attempt, and one that never verifies and must stop after exactly 25 program writes. The bench drives these through a behavioural flash model that stores a corrupted byte for a preset number of program writes. The scoreboard therefore knows in advance how many program strobes each request must produce. The same model timestamps every strobe, data and enable edge, and checks the nanosecond windows on each bus cycle of every attempt. A second request is injected in the middle of a retrying sequence to show that it is dropped.

// File: rtl/fpv_pkg.sv
`timescale 1ns/1ps
// Package: shared types, command codes and the ns-to-cycles conversion
// for the flash program-verify sequencer. Assumes an 8-bit command set.
package fpv_pkg;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } bus_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_PROG,
        SQ_PWAIT,
        SQ_VCMD,
        SQ_VWAIT,
        SQ_READ,
        SQ_REST
    } seq_state_e;

    localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
    localparam logic [7:0] CMD_PGM_CHECK = 8'hC0;
    localparam logic [7:0] CMD_READ_MODE = 8'h00;

    // Whole clock cycles covering a delay in ns, rounded up, at least one.
    function automatic int ns_to_cyc(input longint ns, input longint hz);
        longint c;
        c = (ns * hz + longint'(999_999_999)) / longint'(1_000_000_000);
        return (c < 1) ? 1 : int'(c);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpv_wait.sv
`timescale 1ns/1ps
// Module: fpv_wait
// Down-counter that gives a one-cycle 'expired' pulse a loaded number of
// cycles after 'load'. Assumes load_val >= 1. A new load restarts it.
module fpv_wait #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;
    logic             running;

    // Count down the loaded delay and flag its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                cnt     <= load_val;
                running <= 1'b1;
            end else if (running) begin
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R4/R5: a wait only ends after one was started.
    a_r4_expire_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(running));

endmodule

// File: rtl/fpv_bus.sv
`timescale 1ns/1ps
// Module: fpv_bus
// Runs one flash bus cycle per 'start': a write (enable, strobe low for WL
// cycles, strobe high for WH cycles with data held) or a read (enable and
// output enable for RD cycles, then sample). All pins are registered.
// Assumes 'start' only arrives while no cycle is running.
module fpv_bus
    import fpv_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int WL     = 4,
    parameter int WH     = 1,
    parameter int RD     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  bus_op_e           kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dout,
    output logic              fl_doe,
    input  logic [DATA_W-1:0] fl_din,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int CW  = $clog2(max_of(max_of(WL, WH), RD) + 1);
    localparam int LOW = $clog2(WL + 2);

    typedef enum logic [2:0] {PH_IDLE, PH_SET, PH_LOW, PH_HIGH, PH_RD} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;

    // Step through the phases of a bus cycle and drive the flash pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            cyc_done <= 1'b0;
            rdata    <= '0;
            fl_addr  <= '0;
            fl_dout  <= '0;
            fl_doe   <= 1'b0;
            fl_ce_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
        end else begin
            cyc_done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    fl_addr <= addr;
                    fl_ce_n <= 1'b0;
                    if (kind == OP_WRITE) begin
                        fl_dout <= wdata;
                        fl_doe  <= 1'b1;
                        ph      <= PH_SET;
                    end else begin
                        fl_oe_n <= 1'b0;
                        cnt     <= CW'(RD - 1);
                        ph      <= PH_RD;
                    end
                end
                PH_SET: begin
                    fl_we_n <= 1'b0;
                    cnt     <= CW'(WL - 1);
                    ph      <= PH_LOW;
                end
                PH_LOW: if (cnt == '0) begin
                    fl_we_n <= 1'b1;
                    cnt     <= CW'(WH - 1);
                    ph      <= PH_HIGH;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HIGH: if (cnt == '0) begin
                    fl_ce_n  <= 1'b1;
                    fl_doe   <= 1'b0;
                    cyc_done <= 1'b1;
                    ph       <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_RD: if (cnt == '0) begin
                    rdata    <= fl_din;
                    fl_oe_n  <= 1'b1;
                    fl_ce_n  <= 1'b1;
                    cyc_done <= 1'b1;
                    ph       <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Checker state: length of the current strobe-low run, saturating.
    logic [LOW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n || fl_we_n) low_run <= '0;
        else if (low_run != LOW'(WL)) low_run <= low_run + 1'b1;
    end

    // R3: the strobe never rises before WL low cycles.
    a_r3_strobe_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_run == LOW'(WL)));

    // R3: the strobe only falls while the chip is enabled and data is driven.
    a_r3_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> (!fl_ce_n && fl_doe));

endmodule

// File: rtl/fpv_seq.sv
`timescale 1ns/1ps
// Module: fpv_seq (top)
// Programs one byte into a NOR flash and checks it: setup command, program
// write, program wait, verify command, settle wait, read-back, compare, and
// retry up to MAX_TRIES. It always ends with the read-mode command, then
// pulses done or fail. Assumes the flash high voltage is already applied.
module fpv_seq
    import fpv_pkg::*;
#(
    parameter int CLK_HZ          = 50_000_000,
    parameter int ADDR_W          = 17,
    parameter int DATA_W          = 8,
    parameter int MAX_TRIES       = 25,
    parameter int T_WE_LOW_NS     = 80,
    parameter int T_WE_HIGH_NS    = 20,
    parameter int T_ADDR_HOLD_NS  = 60,
    parameter int T_DATA_SETUP_NS = 50,
    parameter int T_PROG_NS       = 10_000,
    parameter int T_VERIFY_NS     = 6_000,
    parameter int T_ACCESS_NS     = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dout,
    output logic              fl_doe,
    input  logic [DATA_W-1:0] fl_din,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int WL_C   = max_of(max_of(ns_to_cyc(T_WE_LOW_NS, CLK_HZ),
                                          ns_to_cyc(T_ADDR_HOLD_NS, CLK_HZ)),
                                   ns_to_cyc(T_DATA_SETUP_NS, CLK_HZ));
    localparam int WH_C   = ns_to_cyc(T_WE_HIGH_NS, CLK_HZ);
    localparam int RD_C   = ns_to_cyc(T_ACCESS_NS, CLK_HZ);
    localparam int PROG_C = ns_to_cyc(T_PROG_NS, CLK_HZ);
    localparam int VFY_C  = ns_to_cyc(T_VERIFY_NS, CLK_HZ);
    localparam int CNT_W  = $clog2(max_of(PROG_C, VFY_C) + 1);
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);

    seq_state_e        state;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data;
    logic [TRY_W-1:0]  tries;
    logic              pass_q;

    logic              b_start;
    bus_op_e           b_kind;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_data;
    logic              b_done;
    logic [DATA_W-1:0] b_rdata;

    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_exp;

    fpv_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WL     (WL_C),
        .WH     (WH_C),
        .RD     (RD_C)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (b_start),
        .kind     (b_kind),
        .addr     (b_addr),
        .wdata    (b_data),
        .cyc_done (b_done),
        .rdata    (b_rdata),
        .fl_addr  (fl_addr),
        .fl_dout  (fl_dout),
        .fl_doe   (fl_doe),
        .fl_din   (fl_din),
        .fl_ce_n  (fl_ce_n),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n)
    );

    fpv_wait #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    assign busy = (state != SQ_IDLE);

    // Sequence the program/verify steps, issue bus cycles and waits, count tries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            tries    <= '0;
            pass_q   <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            b_start  <= 1'b0;
            b_kind   <= OP_WRITE;
            b_addr   <= '0;
            b_data   <= '0;
            t_load   <= 1'b0;
            t_val    <= '0;
        end else begin
            b_start <= 1'b0;
            t_load  <= 1'b0;
            done    <= 1'b0;
            fail    <= 1'b0;
            case (state)
                SQ_IDLE: if (req_valid) begin
                    tgt_addr <= req_addr;
                    tgt_data <= req_data;
                    tries    <= '0;
                    b_start  <= 1'b1;
                    b_kind   <= OP_WRITE;
                    b_addr   <= req_addr;
                    b_data   <= DATA_W'(CMD_PGM_SETUP);
                    state    <= SQ_SETUP;
                end
                SQ_SETUP: if (b_done) begin
                    b_start <= 1'b1;
                    b_kind  <= OP_WRITE;
                    b_addr  <= tgt_addr;
                    b_data  <= tgt_data;
                    state   <= SQ_PROG;
                end
                SQ_PROG: if (b_done) begin
                    tries  <= tries + 1'b1;
                    t_load <= 1'b1;
                    t_val  <= CNT_W'(PROG_C);
                    state  <= SQ_PWAIT;
                end
                SQ_PWAIT: if (t_exp) begin
                    b_start <= 1'b1;
                    b_kind  <= OP_WRITE;
                    b_addr  <= tgt_addr;
                    b_data  <= DATA_W'(CMD_PGM_CHECK);
                    state   <= SQ_VCMD;
                end
                SQ_VCMD: if (b_done) begin
                    t_load <= 1'b1;
                    t_val  <= CNT_W'(VFY_C);
                    state  <= SQ_VWAIT;
                end
                SQ_VWAIT: if (t_exp) begin
                    b_start <= 1'b1;
                    b_kind  <= OP_READ;
                    b_addr  <= tgt_addr;
                    state   <= SQ_READ;
                end
                SQ_READ: if (b_done) begin
                    b_start <= 1'b1;
                    b_kind  <= OP_WRITE;
                    b_addr  <= tgt_addr;
                    if (b_rdata == tgt_data) begin
                        pass_q <= 1'b1;
                        b_data <= DATA_W'(CMD_READ_MODE);
                        state  <= SQ_REST;
                    end else if (tries == TRY_W'(MAX_TRIES)) begin
                        pass_q <= 1'b0;
                        b_data <= DATA_W'(CMD_READ_MODE);
                        state  <= SQ_REST;
                    end else begin
                        b_data <= DATA_W'(CMD_PGM_SETUP);
                        state  <= SQ_SETUP;
                    end
                end
                SQ_REST: if (b_done) begin
                    done  <= pass_q;
                    fail  <= !pass_q;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R11: the two end reports exclude each other.
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R7: done is a single-cycle pulse.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the attempt count never passes the limit.
    a_r9_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(MAX_TRIES));

    // R6: no bus contention during reads.
    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_doe);

    // R10: the target stays fixed while a sequence runs.
    a_r10_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(tgt_addr)));

endmodule

// File: tb/fpv_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural flash model with timing monitors plus a scoreboard.
// The driver queues the expected outcome of each request; the monitor pops it
// when done or fail appears.
module fpv_seq_bench;

    localparam int AW = 17;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, done, fail;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout;
    logic          fl_doe;
    logic [DW-1:0] fl_din;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    always #10 clk = ~clk;

    fpv_seq u_fpv_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .fail(fail),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0]    mem [int];
    logic [7:0]    cmd = 8'h00;
    logic [7:0]    rd_val = 8'hFF;
    logic [AW-1:0] lat_addr = '0;
    logic [AW-1:0] exp_addr = '0;
    int            fail_budget = 0;
    int            pulses = 0;
    time           t_fall = 0, t_rise = 0, t_dchg = 0, t_prog = 0, t_c0 = 0;
    bit            seen_rise = 0, prog_pend = 0, vfy_arm = 0;

    assign fl_din = rd_val;

    always @(fl_dout or fl_doe) t_dchg = $time;

    // Falling strobe: latch the address, check high time and program wait.
    always @(negedge fl_we_n) if (!fl_ce_n) begin
        t_fall   = $time;
        lat_addr = fl_addr;
        if (seen_rise) check(($time - t_rise) >= 20, "R3 strobe high ns", $time - t_rise, 20);
        if (prog_pend) begin
            check(($time - t_prog) >= 10000, "R4 program wait ns", $time - t_prog, 10000);
            prog_pend = 0;
        end
    end

    // Rising strobe: take data, check low time and setup, run the command.
    always @(posedge fl_we_n) if (!fl_ce_n) begin
        check(($time - t_fall) >= 80, "R3 strobe low ns", $time - t_fall, 80);
        check(($time - t_dchg) >= 50, "R3 data setup ns", $time - t_dchg, 50);
        t_rise    = $time;
        seen_rise = 1;
        if (cmd == 8'h40) begin
            pulses++;
            check(lat_addr == exp_addr, "R2 program address", lat_addr, exp_addr);
            if (fail_budget > 0) begin
                mem[int'(lat_addr)] = fl_dout ^ 8'h01;
                fail_budget--;
            end else begin
                mem[int'(lat_addr)] = fl_dout;
            end
            t_prog    = $time;
            prog_pend = 1;
            cmd       = 8'hEE;
        end else begin
            cmd = fl_dout;
            if (fl_dout == 8'hC0) begin
                t_c0    = $time;
                vfy_arm = 1;
            end
        end
    end

    // Address must not move soon after the falling strobe.
    always @(fl_addr) if (!fl_ce_n && seen_rise)
        if (($time - t_fall) < 60) check(0, "R3 address hold ns", $time - t_fall, 60);

    // Output enable: check no drive, verify settle time, present the data.
    always @(negedge fl_oe_n) begin
        #1;
        check(!fl_doe, "R6 bus released on read", fl_doe, 0);
        check(vfy_arm && cmd == 8'hC0, "R5 verify command before read", cmd, 8'hC0);
        check(($time - 1 - t_c0) >= 6000, "R5 verify settle ns", $time - 1 - t_c0, 6000);
        vfy_arm = 0;
        rd_val = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 8'hFF;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        bit            ok;
        int            npulse;
        bit            poked;
        logic [AW-1:0] poke_addr;
    } exp_t;

    exp_t sb[$];
    int   ended = 0;
    bit   prev_end = 0;

    // Monitor: pop the expected outcome on each end pulse and compare.
    always @(negedge clk) if (rst_n) begin
        if (done || fail) begin
            check(!(done && fail), "R11 done and fail together", {done, fail}, 2);
            check(!prev_end, "R7 end pulse longer than one cycle", 1, 0);
            if (sb.size() == 0) begin
                check(0, "R11 end with no request", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(done == e.ok, e.ok ? "R7 done expected" : "R9 fail expected", done, e.ok);
                check(pulses == e.npulse, e.ok ? "R8 program writes" : "R9 program writes",
                      pulses, e.npulse);
                check(cmd == 8'h00, "R7 read mode restored", cmd, 0);
                check(!busy, "R7 busy low at end", busy, 0);
                if (e.ok) check(mem[int'(e.addr)] == e.data, "R8 stored byte",
                                mem[int'(e.addr)], e.data);
                if (e.poked) check(!mem.exists(int'(e.poke_addr)), "R10 ignored request programmed",
                                   1, 0);
            end
            ended++;
        end
        prev_end = done || fail;
    end

    // Driver: arm the model, queue the expectation, pulse the request, wait.
    task automatic run_req(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int nfail, input bit poke, input logic [AW-1:0] pa);
        exp_t e;
        int   target;
        e.addr = a; e.data = d; e.poked = poke; e.poke_addr = pa;
        e.ok     = (nfail < 25);
        e.npulse = (nfail < 25) ? nfail + 1 : 25;
        fail_budget = nfail;
        pulses      = 0;
        exp_addr    = a;
        sb.push_back(e);
        target = ended + 1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R2 request accepted", busy, 1);
        if (poke) begin
            repeat (900) @(negedge clk);
            check(busy, "R10 still busy at second request", busy, 1);
            req_valid = 1'b1; req_addr = pa; req_data = 8'h77;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait (ended == target);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({fl_ce_n, fl_we_n, fl_oe_n, fl_doe, busy, done, fail} == 7'b1110000,
              "R1 pins in reset", {fl_ce_n, fl_we_n, fl_oe_n, fl_doe, busy, done, fail}, 7'b1110000);
        rst_n = 1'b1;
        @(negedge clk);
        check({fl_ce_n, fl_we_n, fl_oe_n, fl_doe, busy, done, fail} == 7'b1110000,
              "R1 pins after reset", {fl_ce_n, fl_we_n, fl_oe_n, fl_doe, busy, done, fail}, 7'b1110000);
        run_req(17'h00123, 8'hA5, 0, 0, '0);           // R7 first-try pass
        run_req(17'h0BEEF, 8'h3C, 3, 1, 17'h00456);    // R8 retries, R10 poke
        run_req(17'h00001, 8'h00, 24, 0, '0);          // R8 pass on last attempt
        run_req(17'h00002, 8'h5A, 25, 0, '0);          // R9 never verifies
        run_req(17'h1FFFF, 8'hFF, 0, 0, '0);           // R2 top address after a fail
        check(sb.size() == 0, "R11 every request ended", sb.size(), 0);
        finish_up();
    end

endmodule